// File: doc/BRIEF.md
# Banked Interrupt Vector Controller

This block decides when a banked microcontroller's program counter is redirected to the reset vector or to an interrupt vector. It watches an external interrupt pin and two timer overflow pulses. It latches each event in a pending flag of its own. When a pending source is enabled, the global enable is set and the return-address stack has room, the block raises a vector-load strobe. With that strobe it gives the 13-bit vector address and the target bank, requests a push of the return address, asks for the global enable to be cleared, and acknowledges the winning source so that its flag drops.

The reset vector always lands in bank 0. The external interrupt also lands in bank 0. The two timer vectors land inside whichever bank is selected at that moment. The stack memory, the timers, the enable registers and instruction execution sit outside the block.

Top module: `intvec_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `vec_load` is 1, `vec_addr` is 000H, `vec_bank` is 0, and `push_req` and all acknowledges are 0. No interrupt is vectored in that cycle. The reset vector load does not repeat afterwards.
- R2: A falling edge on `ext_irq_n` sets the external pending flag. Servicing it drives `vec_addr` = 004H with `vec_bank` = 0 and raises `ack_ext`.
- R3: A 1 on `tm0_ovf` sets the timer 0 pending flag. Servicing it drives `vec_addr` = 008H with `vec_bank` equal to `bank_cur` in that cycle, and raises `ack_tm0`.
- R4: A 1 on `tm1_ovf` sets the timer 1 pending flag. Servicing it drives `vec_addr` = 00CH with `vec_bank` equal to `bank_cur`, and raises `ack_tm1`.
- R5: No interrupt is vectored while `glb_en` is 0, while `stack_full` is 1, or while the source's own enable is 0. A blocked flag stays pending and is serviced once the block is lifted.
- R6: When several enabled sources are pending, exactly one is acknowledged. The order is external, then timer 0, then timer 1.
- R7: `push_req` and `glb_en_clr` are 1 exactly in the cycles where an interrupt is vectored. In those cycles `vec_load` is also 1.
- R8: An acknowledge clears the pending flag on the next clock edge. An event of the same source that arrives in the acknowledge cycle leaves the flag set, so the source is vectored again.
- R9: Only a falling edge of `ext_irq_n` counts. A pin held low, or held high, creates no new pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_n | input | 1 | External interrupt pin, falling edge active |
| tm0_ovf | input | 1 | Timer 0 overflow pulse |
| tm1_ovf | input | 1 | Timer 1 overflow pulse |
| en_ext | input | 1 | External interrupt enable |
| en_tm0 | input | 1 | Timer 0 interrupt enable |
| en_tm1 | input | 1 | Timer 1 interrupt enable |
| glb_en | input | 1 | Global interrupt enable |
| stack_full | input | 1 | Return stack has no free entry |
| bank_cur | input | 3 | Currently selected program bank |
| vec_load | output | 1 | Load `vec_addr`/`vec_bank` into the program counter |
| vec_addr | output | 13 | Vector address within the bank |
| vec_bank | output | 3 | Target bank of the vector |
| push_req | output | 1 | Push the return address onto the stack |
| glb_en_clr | output | 1 | Clear the global interrupt enable |
| ack_ext | output | 1 | External request serviced |
| ack_tm0 | output | 1 | Timer 0 request serviced |
| ack_tm1 | output | 1 | Timer 1 request serviced |

## Verification
Two things can fall in the same cycle: the acknowledge that clears a source's pending flag, and a fresh event from that same source. The bench provokes this on purpose. It pends timer 0 and then pulses `tm0_ovf` in the very cycle timer 0 is vectored. It then checks that a second vector to 008H follows, and not a silent loss. Random stimulus also hits this overlap often, and a bench model of the flags judges every cycle. The model also covers the case where a request arrives in the reset-vector cycle and must wait for the next one.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
   localparam int unsigned NSRC    = 3;
   localparam int unsigned SRC_EXT = 0;
   localparam int unsigned SRC_TM0 = 1;
   localparam int unsigned SRC_TM1 = 2;
endpackage

// File: rtl/intvec_pend_flag.sv
module intvec_pend_flag #(
   parameter bit EDGE_MODE = 1'b0,
   parameter bit ACT_LOW   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_in,
   input  logic ack_in,
   output logic pend_o
);
   logic hit;
   logic pend_q;

   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= ACT_LOW;
            else        prev_q <= ev_in;
         end
         assign hit = ACT_LOW ? (prev_q & ~ev_in) : (~prev_q & ev_in);
      end else begin : g_pulse
         assign hit = ACT_LOW ? ~ev_in : ev_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= hit | (pend_q & ~ack_in);
   end

   assign pend_o = pend_q;

   AST_ACK_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in && !hit) |=> !pend_o); // R8
   AST_SET_ON_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in && hit) |=> pend_o); // R8
   AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !ack_in) |=> pend_o); // R5
endmodule

// File: rtl/intvec_arbiter.sv
module intvec_arbiter #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("intvec_arbiter: N must be at least 1");
      end
      genvar gi;
      for (gi = 0; gi < N; gi++) begin : g_slot
         if (gi == 0) begin : g_top
            assign grant_o[gi] = req_i[gi];
         end else begin : g_lower
            assign grant_o[gi] = req_i[gi] & ~(|req_i[gi-1:0]);
         end
      end
   endgenerate

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)); // R6
   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_i) |-> (|grant_o)); // R6
endmodule

// File: rtl/intvec_vec_sel.sv
module intvec_vec_sel #(
   parameter int unsigned       N          = 3,
   parameter int unsigned       PC_W       = 13,
   parameter int unsigned       BANK_W     = 3,
   parameter logic [N*PC_W-1:0] VEC_TABLE  = '0,
   parameter logic [N-1:0]      BANK_LOCAL = '0,
   parameter logic [PC_W-1:0]   RESET_VEC  = '0
) (
   input  logic              boot_i,
   input  logic [N-1:0]      grant_i,
   input  logic [BANK_W-1:0] bank_cur_i,
   output logic [PC_W-1:0]   addr_o,
   output logic [BANK_W-1:0] bank_o
);
   logic is_local;

   always_comb begin
      addr_o   = '0;
      is_local = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (grant_i[i]) begin
            addr_o   = addr_o | VEC_TABLE[i*PC_W +: PC_W];
            is_local = is_local | BANK_LOCAL[i];
         end
      end
      bank_o = is_local ? bank_cur_i : '0;
      if (boot_i) begin
         addr_o = RESET_VEC;
         bank_o = '0;
      end
   end
endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl #(
   parameter int unsigned PC_W        = 13,
   parameter int unsigned BANK_W      = 3,
   parameter int unsigned RESET_VEC   = 0,
   parameter int unsigned VEC_EXT     = 4,
   parameter int unsigned VEC_TM0     = 8,
   parameter int unsigned VEC_TM1     = 12,
   parameter bit          EXT_ACT_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_irq_n,
   input  logic              tm0_ovf,
   input  logic              tm1_ovf,
   input  logic              en_ext,
   input  logic              en_tm0,
   input  logic              en_tm1,
   input  logic              glb_en,
   input  logic              stack_full,
   input  logic [BANK_W-1:0] bank_cur,
   output logic              vec_load,
   output logic [PC_W-1:0]   vec_addr,
   output logic [BANK_W-1:0] vec_bank,
   output logic              push_req,
   output logic              glb_en_clr,
   output logic              ack_ext,
   output logic              ack_tm0,
   output logic              ack_tm1
);
   import intvec_pkg::*;

   localparam logic [NSRC*PC_W-1:0] VTAB =
      {VEC_TM1[PC_W-1:0], VEC_TM0[PC_W-1:0], VEC_EXT[PC_W-1:0]};
   localparam logic [NSRC-1:0] LOCAL_MASK = NSRC'(3'b110);
   localparam logic [PC_W-1:0] RST_ADDR   = RESET_VEC[PC_W-1:0];

   generate
      if (PC_W < 4 || PC_W > 32) begin : g_bad_pcw
         $error("intvec_ctrl: PC_W out of range");
      end
      if (BANK_W < 1) begin : g_bad_bankw
         $error("intvec_ctrl: BANK_W must be at least 1");
      end
      if (VEC_EXT >= (64'd1 << PC_W) || VEC_TM0 >= (64'd1 << PC_W) ||
          VEC_TM1 >= (64'd1 << PC_W) || RESET_VEC >= (64'd1 << PC_W)) begin : g_bad_vec
         $error("intvec_ctrl: a vector does not fit in PC_W bits");
      end
   endgenerate

   logic            boot_q;
   logic [NSRC-1:0] ev;
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] en_src;
   logic [NSRC-1:0] req;
   logic [NSRC-1:0] grant;
   logic            may_take;
   logic            take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot_q <= 1'b1;
      else        boot_q <= 1'b0;
   end

   assign ev[SRC_EXT]     = ext_irq_n;
   assign ev[SRC_TM0]     = tm0_ovf;
   assign ev[SRC_TM1]     = tm1_ovf;
   assign en_src[SRC_EXT] = en_ext;
   assign en_src[SRC_TM0] = en_tm0;
   assign en_src[SRC_TM1] = en_tm1;

   generate
      genvar gs;
      for (gs = 0; gs < NSRC; gs++) begin : g_src
         if (gs == SRC_EXT) begin : g_pin
            intvec_pend_flag #(.EDGE_MODE(1'b1), .ACT_LOW(EXT_ACT_LOW)) u_flag (
               .clk(clk), .rst_n(rst_n), .ev_in(ev[gs]),
               .ack_in(grant[gs]), .pend_o(pend[gs]));
         end else begin : g_tmr
            intvec_pend_flag #(.EDGE_MODE(1'b0), .ACT_LOW(1'b0)) u_flag (
               .clk(clk), .rst_n(rst_n), .ev_in(ev[gs]),
               .ack_in(grant[gs]), .pend_o(pend[gs]));
         end
      end
   endgenerate

   assign may_take = glb_en & ~stack_full & ~boot_q;
   assign req      = pend & en_src & {NSRC{may_take}};

   intvec_arbiter #(.N(NSRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(req), .grant_o(grant));

   assign take = |grant;

   intvec_vec_sel #(
      .N(NSRC), .PC_W(PC_W), .BANK_W(BANK_W),
      .VEC_TABLE(VTAB), .BANK_LOCAL(LOCAL_MASK), .RESET_VEC(RST_ADDR)
   ) u_sel (
      .boot_i(boot_q), .grant_i(grant), .bank_cur_i(bank_cur),
      .addr_o(vec_addr), .bank_o(vec_bank));

   assign vec_load   = boot_q | take;
   assign push_req   = take;
   assign glb_en_clr = take;
   assign ack_ext    = grant[SRC_EXT];
   assign ack_tm0    = grant[SRC_TM0];
   assign ack_tm1    = grant[SRC_TM1];

   AST_BOOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      boot_q |=> !boot_q); // R1
   AST_BOOT_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      boot_q |-> (!push_req && vec_addr == RST_ADDR && vec_bank == '0)); // R1
   AST_PUSH_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      push_req |-> (!stack_full && glb_en && vec_load)); // R5
   AST_EXT_IN_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ext |-> (vec_bank == '0 && vec_addr == VEC_EXT[PC_W-1:0])); // R2
   AST_TM0_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      ack_tm0 |-> (vec_bank == bank_cur && vec_addr == VEC_TM0[PC_W-1:0])); // R3
   AST_TM1_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      ack_tm1 |-> (vec_bank == bank_cur && vec_addr == VEC_TM1[PC_W-1:0])); // R4
   AST_CLR_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      glb_en_clr |-> push_req); // R7
endmodule

// File: tb/intvec_ctrl_bench.sv
module intvec_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_irq_n = 1'b1, tm0_ovf = 1'b0, tm1_ovf = 1'b0;
   logic       en_ext = 1'b0, en_tm0 = 1'b0, en_tm1 = 1'b0;
   logic       glb_en = 1'b0, stack_full = 1'b0;
   logic [2:0] bank_cur = 3'd0;
   logic        vec_load, push_req, glb_en_clr, ack_ext, ack_tm0, ack_tm1;
   logic [12:0] vec_addr;
   logic [2:0]  vec_bank;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [2:0] m_pend = 3'b000;
   logic       m_prev = 1'b1;

   always #4 clk = ~clk;

   intvec_ctrl u_intvec_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .tm0_ovf(tm0_ovf),
      .tm1_ovf(tm1_ovf), .en_ext(en_ext), .en_tm0(en_tm0), .en_tm1(en_tm1),
      .glb_en(glb_en), .stack_full(stack_full), .bank_cur(bank_cur),
      .vec_load(vec_load), .vec_addr(vec_addr), .vec_bank(vec_bank),
      .push_req(push_req), .glb_en_clr(glb_en_clr), .ack_ext(ack_ext),
      .ack_tm0(ack_tm0), .ack_tm1(ack_tm1));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] pick(input logic [2:0] r);
      if (r[0])      return 3'b001;
      else if (r[1]) return 3'b010;
      else if (r[2]) return 3'b100;
      return 3'b000;
   endfunction

   function automatic logic [12:0] vec_of(input logic [2:0] g);
      return g[0] ? 13'h004 : g[1] ? 13'h008 : 13'h00C;
   endfunction

   task automatic step(input logic pin, input logic t0, input logic t1,
                       input logic e0, input logic e1, input logic e2,
                       input logic ge, input logic sf, input logic [2:0] bk);
      logic [2:0] g;
      string tg;
      @(negedge clk);
      ext_irq_n = pin; tm0_ovf = t0; tm1_ovf = t1;
      en_ext = e0; en_tm0 = e1; en_tm1 = e2;
      glb_en = ge; stack_full = sf; bank_cur = bk;
      #1;
      g = pick(m_pend & {e2, e1, e0} & {3{ge & ~sf}});
      chk("R7", {31'd0, push_req}, {31'd0, g != 3'b000});
      chk("R7", {31'd0, glb_en_clr}, {31'd0, g != 3'b000});
      chk((g != 3'b000) ? "R6" : "R5", {31'd0, vec_load}, {31'd0, g != 3'b000});
      chk("R6", {29'd0, ack_tm1, ack_tm0, ack_ext}, {29'd0, g});
      if (g != 3'b000) begin
         tg = g[0] ? "R2" : g[1] ? "R3" : "R4";
         chk(tg, {19'd0, vec_addr}, {19'd0, vec_of(g)});
         chk(tg, {29'd0, vec_bank}, {29'd0, g[0] ? 3'd0 : bk});
      end
      m_pend = (m_pend & ~g) | {t1, t0, m_prev & ~pin};
      m_prev = pin;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic pin_r;
      void'($urandom(32'h1F2E3D4C));
      repeat (3) @(negedge clk);
      #1;
      // R1: held in reset
      chk("R1", {31'd0, vec_load}, 32'd1);
      chk("R1", {19'd0, vec_addr}, 32'd0);
      chk("R1", {29'd0, push_req, ack_ext, ack_tm0}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      tm0_ovf = 1'b1; en_tm0 = 1'b1; glb_en = 1'b1;
      #1;
      // R1: first cycle after release, timer 0 arriving now must not vector here
      chk("R1", {31'd0, vec_load}, 32'd1);
      chk("R1", {29'd0, vec_bank}, 32'd0);
      chk("R1", {28'd0, push_req, ack_ext, ack_tm0, ack_tm1}, 32'd0);
      m_pend = 3'b010;
      // timer 0 from the boot cycle is serviced in bank 5
      step(1, 0, 0, 1, 1, 1, 1, 0, 3'd5);
      chk("R3", {31'd0, ack_tm0}, 32'd1);
      step(1, 0, 0, 1, 1, 1, 1, 0, 3'd5);
      chk("R1", {31'd0, vec_load}, 32'd0);

      // R6: all three pending at once
      step(0, 1, 1, 1, 1, 1, 0, 0, 3'd2);
      step(0, 0, 0, 1, 1, 1, 1, 0, 3'd2);
      chk("R6", {31'd0, ack_ext}, 32'd1);
      step(0, 0, 0, 1, 1, 1, 1, 0, 3'd2);
      chk("R6", {31'd0, ack_tm0}, 32'd1);
      step(0, 0, 0, 1, 1, 1, 1, 0, 3'd6);
      chk("R4", {29'd0, vec_bank}, 32'd6);

      // R9: pin held low creates nothing new
      repeat (4) step(0, 0, 0, 1, 1, 1, 1, 0, 3'd1);
      chk("R9", {31'd0, vec_load}, 32'd0);

      // R5: stack full blocks, then release
      step(1, 0, 0, 1, 1, 1, 1, 0, 3'd1);
      step(0, 0, 0, 1, 1, 1, 1, 1, 3'd1);
      repeat (3) step(0, 0, 0, 1, 1, 1, 1, 1, 3'd1);
      chk("R5", {31'd0, vec_load}, 32'd0);
      step(0, 0, 0, 0, 1, 1, 1, 0, 3'd1);
      chk("R5", {31'd0, vec_load}, 32'd0);
      step(0, 0, 0, 1, 1, 1, 1, 0, 3'd1);
      chk("R5", {31'd0, ack_ext}, 32'd1);

      // R8: new timer 0 pulse in its own acknowledge cycle
      step(1, 1, 0, 1, 1, 1, 0, 0, 3'd3);
      step(1, 1, 0, 1, 1, 1, 1, 0, 3'd3);
      chk("R8", {31'd0, ack_tm0}, 32'd1);
      step(1, 0, 0, 1, 1, 1, 1, 0, 3'd3);
      chk("R8", {31'd0, ack_tm0}, 32'd1);
      step(1, 0, 0, 1, 1, 1, 1, 0, 3'd3);
      chk("R8", {31'd0, ack_tm0}, 32'd0);

      // random mix
      pin_r = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 4 == 0) pin_r = ~pin_r;
         step(pin_r, ($urandom % 4) == 0, ($urandom % 4) == 0,
              ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
              ($urandom % 4) != 0, ($urandom % 5) == 0, 3'($urandom));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule